// File: doc/BRIEF.md
# Host Link Watchdog Monitor

This block guards a serial host link against silence. A frame decoder elsewhere in the chip emits a one-cycle pulse for every command frame it accepts. Once software enables the monitor, it measures the time since the last such pulse against one of four windows chosen by a two-bit select. If a window runs out, the block emits a one-cycle timeout event and raises a sticky error flag. The window then restarts on its own.

The time base is a microsecond tick made by dividing the system clock. The divider is derived from the clock and tick frequency parameters. The four windows are parameters in tick units. By default they are 400 µs for select 0, and 400 ms, 800 ms and 1200 ms for selects 1 to 3. The window counter is sized for the longest one, so both the short setting and the long settings share one counter.

The error flag survives a status read for as long as the condition that raised it persists. The condition counts as removed once a valid frame arrives or the monitor is disabled. After that, the next read clears the flag. A mask input keeps timeouts from reaching the flag, while the raw timeout event still fires.

Top module: `wd_serial_watchdog`

## Requirements
- R1: After reset, `wdError` and `timeoutPulse` are both 0.
- R2: While `wdEnable` is 0, no timeout event occurs and `wdError` is never set, however long no frame arrives.
- R3: One tick lasts CLK_HZ/TICK_HZ clock cycles. When the monitor is enabled with `timeoutSel` = 0, the first `timeoutPulse` appears WIN0_US ticks after enabling, counted from the last clock edge that sampled `wdEnable` low.
- R4: `timeoutPulse` lasts exactly one cycle. After it, the window restarts, so with no frames the next event follows one full window later.
- R5: A `frameValid` pulse restarts the window from zero. Frames spaced closer than the window produce no event, and the event appears one full window after the last frame.
- R6: A change of `timeoutSel` restarts the window, and the new length applies from that point. Select 1 uses WIN1_US ticks.
- R7: A timeout with `errMask` low sets `wdError` in the same cycle as the event. A `statusRead` does not clear the flag while the cause persists. A valid frame removes the cause, and a later `statusRead` clears the flag one cycle after it is sampled.
- R8: While `errMask` is 1, timeouts still produce `timeoutPulse` but leave `wdError` at 0.
- R9: Select 2 uses a window of WIN2_US ticks and select 3 a window of WIN3_US ticks.
- R10: Disabling the monitor removes the error cause, so a following `statusRead` clears `wdError`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wdEnable | input | 1 | Monitor enable |
| timeoutSel | input | 2 | Window select, 0 to 3 |
| frameValid | input | 1 | One-cycle pulse per accepted command frame |
| statusRead | input | 1 | One-cycle pulse when software reads the error status |
| errMask | input | 1 | Keeps timeouts from setting the error flag |
| wdError | output | 1 | Sticky watchdog error flag |
| timeoutPulse | output | 1 | One-cycle timeout event |

## Verification
The assertions take `frameValid` and `statusRead` to be single-cycle pulses, and they take every window to span at least two clock cycles, so that two timeout events can never be adjacent. The bench drives each control input once, half a cycle before an edge, and always holds pulses for exactly one cycle. It shrinks the windows and the clock-to-tick ratio through parameters, so that every window still lasts hundreds of cycles. It spaces frames and reads well away from expected events, so no read or frame ever coincides with a timeout.

// File: rtl/wd_serial_watchdog_pkg.sv
package wd_serial_watchdog_pkg;

  // Window select encoding: index into the four window parameters.
  typedef enum logic [1:0] {
    WIN_SHORT = 2'd0,
    WIN_MID   = 2'd1,
    WIN_LONG  = 2'd2,
    WIN_MAX   = 2'd3
  } winSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic restart;  // clear prescaler and window counter
    logic count;    // advance the time base
  } wdStrobe_t;

endpackage

// File: rtl/wd_serial_watchdog_datapath.sv
module wd_serial_watchdog_datapath
  import wd_serial_watchdog_pkg::*;
#(
  parameter int TICK_DIV = 50,
  parameter int WIN0_US  = 400,
  parameter int WIN1_US  = 400000,
  parameter int WIN2_US  = 800000,
  parameter int WIN3_US  = 1200000
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdStrobe_t  strobe,
  input  logic [1:0] timeoutSel,
  output logic       expire
);

  localparam int MAX01  = (WIN0_US > WIN1_US) ? WIN0_US : WIN1_US;
  localparam int MAX23  = (WIN2_US > WIN3_US) ? WIN2_US : WIN3_US;
  localparam int MAXWIN = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CNT_W  = $clog2(MAXWIN + 1);
  localparam int PRE_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic             tick;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] lastTick;

  // Microsecond time base: a bypass when the clock is already the tick rate.
  generate
    if (TICK_DIV == 1) begin : gNoDiv
      assign tick = strobe.count;
    end else begin : gDiv
      logic [PRE_W-1:0] preCnt;
      assign tick = strobe.count && (preCnt == PRE_W'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (strobe.restart) begin
          preCnt <= '0;
        end else if (strobe.count) begin
          preCnt <= tick ? '0 : preCnt + 1'b1;
        end
      end
    end
  endgenerate

  // Terminal count of the selected window, in ticks minus one.
  always_comb begin
    unique case (winSel_e'(timeoutSel))
      WIN_SHORT: lastTick = CNT_W'(WIN0_US - 1);
      WIN_MID:   lastTick = CNT_W'(WIN1_US - 1);
      WIN_LONG:  lastTick = CNT_W'(WIN2_US - 1);
      default:   lastTick = CNT_W'(WIN3_US - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed <= '0;
    end else if (strobe.restart) begin
      elapsed <= '0;
    end else if (tick) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign expire = tick && (elapsed == lastTick);

endmodule

// File: rtl/wd_serial_watchdog_control.sv
module wd_serial_watchdog_control
  import wd_serial_watchdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdEnable,
  input  logic [1:0] timeoutSel,
  input  logic       frameValid,
  input  logic       statusRead,
  input  logic       errMask,
  input  logic       expire,
  output wdStrobe_t  strobe,
  output logic       wdError,
  output logic       timeoutPulse
);

  logic [1:0] prevSel;
  logic       selChanged;
  logic       fire;
  logic       causeActive;

  assign selChanged = (timeoutSel != prevSel);
  // A frame or a new select in the same cycle wins over an expiring window.
  assign fire = expire && wdEnable && !frameValid && !selChanged;

  assign strobe.restart = !wdEnable || frameValid || selChanged || fire;
  assign strobe.count   = wdEnable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSel      <= '0;
      timeoutPulse <= 1'b0;
      causeActive  <= 1'b0;
      wdError      <= 1'b0;
    end else begin
      prevSel      <= timeoutSel;
      timeoutPulse <= fire;
      if (!wdEnable || frameValid) begin
        causeActive <= 1'b0;
      end else if (fire) begin
        causeActive <= 1'b1;
      end
      if (fire && !errMask) begin
        wdError <= 1'b1;
      end else if (statusRead && !causeActive) begin
        wdError <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wd_serial_watchdog.sv
module wd_serial_watchdog
  import wd_serial_watchdog_pkg::*;
#(
  parameter int CLK_HZ  = 50000000,
  parameter int TICK_HZ = 1000000,
  parameter int WIN0_US = 400,
  parameter int WIN1_US = 400000,
  parameter int WIN2_US = 800000,
  parameter int WIN3_US = 1200000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdEnable,
  input  logic [1:0] timeoutSel,
  input  logic       frameValid,
  input  logic       statusRead,
  input  logic       errMask,
  output logic       wdError,
  output logic       timeoutPulse
);

  localparam int TICK_DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  wdStrobe_t strobe;
  logic      expire;

  wd_serial_watchdog_control uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .wdEnable     (wdEnable),
    .timeoutSel   (timeoutSel),
    .frameValid   (frameValid),
    .statusRead   (statusRead),
    .errMask      (errMask),
    .expire       (expire),
    .strobe       (strobe),
    .wdError      (wdError),
    .timeoutPulse (timeoutPulse)
  );

  wd_serial_watchdog_datapath #(
    .TICK_DIV (TICK_DIV),
    .WIN0_US  (WIN0_US),
    .WIN1_US  (WIN1_US),
    .WIN2_US  (WIN2_US),
    .WIN3_US  (WIN3_US)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .timeoutSel (timeoutSel),
    .expire     (expire)
  );

endmodule

// File: rtl/wd_serial_watchdog_chk.sv
module wd_serial_watchdog_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wdEnable,
  input logic       frameValid,
  input logic       statusRead,
  input logic       errMask,
  input logic       wdError,
  input logic       timeoutPulse
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);  // R4

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> $past(wdEnable));  // R2

  AST_FRAME_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && wdEnable) |=> !timeoutPulse);  // R5

  AST_FLAG_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutPulse && !$past(errMask)) |-> wdError);  // R7

  AST_FLAG_ONLY_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdError) |-> (timeoutPulse && !$past(errMask)));  // R8

  AST_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdError) |-> $past(statusRead));  // R7

endmodule

bind wd_serial_watchdog wd_serial_watchdog_chk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .wdEnable     (wdEnable),
  .frameValid   (frameValid),
  .statusRead   (statusRead),
  .errMask      (errMask),
  .wdError      (wdError),
  .timeoutPulse (timeoutPulse)
);

// File: tb/wd_serial_watchdog_test.sv
module wd_serial_watchdog_test;

  // Bench time base: 4 clocks per tick, windows in ticks.
  localparam int DIV = 4;
  localparam int W0 = 40;
  localparam int W1 = 100;
  localparam int W2 = 200;
  localparam int W3 = 300;

  typedef struct {
    int    cyc;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wdEnable = 1'b0;
  logic [1:0] timeoutSel = 2'd0;
  logic frameValid = 1'b0;
  logic statusRead = 1'b0;
  logic errMask = 1'b0;
  logic wdError;
  logic timeoutPulse;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  expItem_t expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  wd_serial_watchdog #(
    .CLK_HZ  (4000000),
    .TICK_HZ (1000000),
    .WIN0_US (W0),
    .WIN1_US (W1),
    .WIN2_US (W2),
    .WIN3_US (W3)
  ) uut (
    .clk          (clk),
    .rstN         (rstN),
    .wdEnable     (wdEnable),
    .timeoutSel   (timeoutSel),
    .frameValid   (frameValid),
    .statusRead   (statusRead),
    .errMask      (errMask),
    .wdError      (wdError),
    .timeoutPulse (timeoutPulse)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expectAt(input int c, input string req);
    expItem_t it;
    it.cyc = c;
    it.req = req;
    expQ.push_back(it);
  endtask

  task automatic waitCyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic pulseFrame();
    frameValid = 1'b1;
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  task automatic pulseRead();
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  // Monitor: every event must match the head of the expectation queue.
  always @(negedge clk) begin
    if (rstN && timeoutPulse) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2/R4 unexpected event", cyc, -1);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        chk(cyc == it.cyc, it.req, cyc, it.cyc);
      end
    end
  end

  // Watchdog of the bench itself.
  initial begin
    #(20 * 100000);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(wdError == 1'b0, "R1 wdError", wdError, 0);
    chk(timeoutPulse == 1'b0, "R1 timeoutPulse", timeoutPulse, 0);

    // R2: disabled monitor stays silent
    c = cyc;
    waitCyc(c + 1500);
    chk(wdError == 1'b0, "R2 no error while disabled", wdError, 0);

    // R3, R4: first and repeated event on window 0
    c = cyc;
    wdEnable = 1'b1;
    expectAt(c + W0 * DIV, "R3 first event");
    expectAt(c + 2 * W0 * DIV, "R4 restart after event");
    waitCyc(c + W0 * DIV);
    chk(wdError == 1'b1, "R7 flag with event", wdError, 1);
    waitCyc(c + 2 * W0 * DIV + 5);
    chk(expQ.size() == 0, "R4 both events seen", expQ.size(), 0);

    // R7: read while cause persists keeps the flag
    pulseRead();
    chk(wdError == 1'b1, "R7 read with cause", wdError, 1);
    @(negedge clk);
    c = cyc;
    pulseFrame();
    pulseRead();
    chk(wdError == 1'b0, "R7 read after frame clears", wdError, 0);

    // R5: frames closer than the window hold off events
    for (int i = 0; i < 4; i++) begin
      c = cyc;
      waitCyc(c + 100);
      c = cyc;
      pulseFrame();
    end
    chk(wdError == 1'b0, "R5 no flag with frames", wdError, 0);
    expectAt(c + 1 + W0 * DIV, "R5 event after last frame");
    waitCyc(c + 1 + W0 * DIV + 3);
    chk(expQ.size() == 0, "R5 event seen", expQ.size(), 0);
    chk(wdError == 1'b1, "R5 flag set", wdError, 1);

    // R10: disabling removes the cause
    wdEnable = 1'b0;
    @(negedge clk);
    pulseRead();
    chk(wdError == 1'b0, "R10 read after disable clears", wdError, 0);
    repeat (20) @(negedge clk);

    // R8: masked timeout
    errMask = 1'b1;
    c = cyc;
    wdEnable = 1'b1;
    expectAt(c + W0 * DIV, "R8 masked event");
    waitCyc(c + W0 * DIV + 5);
    chk(wdError == 1'b0, "R8 flag stays low", wdError, 0);
    errMask = 1'b0;

    // R6: select change restarts with window 1
    c = cyc;
    timeoutSel = 2'd1;
    expectAt(c + 1 + W1 * DIV, "R6 window 1");
    waitCyc(c + 1 + W1 * DIV + 3);
    chk(expQ.size() == 0, "R6 event seen", expQ.size(), 0);

    // R9: windows 2 and 3
    c = cyc;
    timeoutSel = 2'd2;
    expectAt(c + 1 + W2 * DIV, "R9 window 2");
    waitCyc(c + 1 + W2 * DIV + 3);
    c = cyc;
    timeoutSel = 2'd3;
    expectAt(c + 1 + W3 * DIV, "R9 window 3");
    waitCyc(c + 1 + W3 * DIV + 3);
    chk(expQ.size() == 0, "R9 events seen", expQ.size(), 0);
    wdEnable = 1'b0;
    repeat (10) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule